// File: doc/BRIEF.md
# System Control Register Bank

This block is a bank of 32-bit control and status registers placed in a 4 KB window on a simple APB-style slave bus. It drives two LED outputs and samples two push-button inputs. It holds a free 32-bit control word and two wall-clock counters, one stepping once per second and one stepping once per hundredth of a second. Software can preset both wall-clock counters. The bank also contains a prescaled event counter: a down-counting prescaler that reloads from a software-set value and bumps an event count on every reload.

All time bases come from the system clock through counter dividers whose ratios are parameters. Only aligned word accesses hit a register. Any other offset reads as zero and ignores writes. Read data is registered, so it appears on the bus one cycle after the access phase, and there are no wait states.

Top module: `sys_ctrl_regs`

## Requirements
- R1: After synchronous reset every readable register (LED, button excepted, MISC, both wall counters, event count, prescaler count, reload value) reads zero, `led_out` is 0 and `prdata` is 0.
- R2: A write to offset 0x00 keeps only data bits [1:0]. A read returns them in bits [1:0] with bits [31:2] zero, and `led_out` shows the stored bits from the cycle after the write.
- R3: Offset 0x08 returns `btn_in` after a two-flop synchroniser in bits [1:0], zero above, and a write to it changes nothing.
- R4: Offset 0x4C stores all 32 written bits and reads them back unchanged.
- R5: The counter at 0x10 increments once every CLK_HZ cycles and the counter at 0x14 once every CLK_HZ/100 cycles, both wrapping from 0xFFFFFFFF to 0.
- R6: A write to 0x10 or 0x14 loads the written value, and counting resumes from it. If the write lands in the same cycle as that counter's tick, the written value is kept and the increment is lost.
- R7: The prescaler count at 0x20 decrements on each prescale tick, one every PS_DIV cycles. On a tick where it is zero, it reloads from the reload value at 0x1C and the event count at 0x18 increments. With a reload value of zero, the event count increments on every tick.
- R8: Offsets 0x18, 0x1C and 0x20 are writable. A write to the event count or prescaler count in a tick cycle overrides that register's tick update, while the other register still follows R7.
- R9: Reads from unmapped offsets, or from offsets with address bits [1:0] not zero, return zero. Writes to them change no register.
- R10: Read data is captured at the access-phase edge and held on `prdata` for exactly the next cycle. `prdata` is zero in every other cycle, including after writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte offset within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| btn_in | input | 2 | Asynchronous push-button levels |
| led_out | output | 2 | LED drive bits |

## Verification
Two functions can meet in the same cycle: a software write to a counter and that counter's own tick. This applies to the hundredth-second wall counter and to the prescaler count. The bench tracks the divider phase in its reference model. It starts a write so that the access-phase edge coincides with the tick, then reads the register back two cycles later. That read must return exactly the written value, not the value plus one or minus one. In the same cycle the event count must still advance if the prescaler was at zero.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned LED_W  = 2;
    localparam int unsigned BTN_W  = 2;
    localparam int unsigned N_WALL = 2;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_LED,
        SEL_BTN,
        SEL_SEC,
        SEL_CENTI,
        SEL_EVT,
        SEL_RELOAD,
        SEL_PSC,
        SEL_AUX
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        s = SEL_NONE;
        if (a[1:0] == 2'b00) begin
            case (a[ADDR_W-1:2])
                10'h000: s = SEL_LED;
                10'h002: s = SEL_BTN;
                10'h004: s = SEL_SEC;
                10'h005: s = SEL_CENTI;
                10'h006: s = SEL_EVT;
                10'h007: s = SEL_RELOAD;
                10'h008: s = SEL_PSC;
                10'h013: s = SEL_AUX;
                default: s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned div);
        return (div > 1) ? $clog2(div) : 1;
    endfunction

endpackage

// File: rtl/tick_div.sv
module tick_div #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = sysctl_pkg::cnt_width(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)                phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                    phase_q <= phase_q + 1'b1;
    end

    assign tick = (phase_q == LAST);
endmodule

// File: rtl/wall_counter.sv
module wall_counter #(
    parameter int unsigned DIV = 100
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load,
    input  logic [sysctl_pkg::DATA_W-1:0] load_val,
    output logic [sysctl_pkg::DATA_W-1:0] value
);
    logic tick;

    tick_div #(.DIV(DIV)) u_div (.clk(clk), .rst(rst), .tick(tick));

    always_ff @(posedge clk) begin
        if (rst)       value <= '0;
        else if (load) value <= load_val;
        else if (tick) value <= value + 1'b1;
    end
endmodule

// File: rtl/event_prescaler.sv
module event_prescaler #(
    parameter int unsigned DIV = 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ld_count,
    input  logic                          ld_pscnt,
    input  logic                          ld_reload,
    input  logic [sysctl_pkg::DATA_W-1:0] wdata,
    output logic [sysctl_pkg::DATA_W-1:0] count,
    output logic [sysctl_pkg::DATA_W-1:0] pscnt,
    output logic [sysctl_pkg::DATA_W-1:0] reload
);
    logic tick;
    logic at_zero;

    tick_div #(.DIV(DIV)) u_div (.clk(clk), .rst(rst), .tick(tick));

    assign at_zero = (pscnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            pscnt  <= '0;
            reload <= '0;
        end else begin
            if (ld_reload) reload <= wdata;

            if (ld_count)              count <= wdata;
            else if (tick && at_zero)  count <= count + 1'b1;

            if (ld_pscnt)   pscnt <= wdata;
            else if (tick)  pscnt <= at_zero ? reload : pscnt - 1'b1;
        end
    end
endmodule

// File: rtl/sys_ctrl_regs.sv
module sys_ctrl_regs
    import sysctl_pkg::*;
#(
    parameter int unsigned CLK_HZ = 25_000_000,
    parameter int unsigned PS_DIV = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [11:0] paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    input  logic [1:0]  btn_in,
    output logic [1:0]  led_out
);
    localparam int unsigned DIV_SEC   = (CLK_HZ >= 1)   ? CLK_HZ       : 1;
    localparam int unsigned DIV_CENTI = (CLK_HZ >= 100) ? CLK_HZ / 100 : 1;

    bus_req_t req;
    always_comb begin
        req.wr   = psel && penable && pwrite;
        req.rd   = psel && penable && !pwrite;
        req.sel  = decode_offset(paddr);
        req.data = pwdata;
    end

    // Button synchroniser
    logic [BTN_W-1:0] btn_m, btn_s;
    always_ff @(posedge clk) begin
        if (rst) begin
            btn_m <= '0;
            btn_s <= '0;
        end else begin
            btn_m <= btn_in;
            btn_s <= btn_m;
        end
    end

    // Plain storage registers
    logic [LED_W-1:0]  led_q;
    logic [DATA_W-1:0] aux_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            led_q <= '0;
            aux_q <= '0;
        end else if (req.wr) begin
            if (req.sel == SEL_LED) led_q <= req.data[LED_W-1:0];
            if (req.sel == SEL_AUX) aux_q <= req.data;
        end
    end
    assign led_out = led_q;

    // Wall-clock counters
    logic [DATA_W-1:0] wall_val [N_WALL];
    for (genvar i = 0; i < N_WALL; i++) begin : g_wall
        localparam int unsigned D = (i == 0) ? DIV_SEC : DIV_CENTI;
        localparam reg_sel_e    S = (i == 0) ? SEL_SEC : SEL_CENTI;
        wall_counter #(.DIV(D)) u_wall (
            .clk      (clk),
            .rst      (rst),
            .load     (req.wr && (req.sel == S)),
            .load_val (req.data),
            .value    (wall_val[i])
        );
    end

    // Prescaled event counter
    logic [DATA_W-1:0] evt_count, evt_pscnt, evt_reload;
    event_prescaler #(.DIV(PS_DIV)) u_evt (
        .clk       (clk),
        .rst       (rst),
        .ld_count  (req.wr && (req.sel == SEL_EVT)),
        .ld_pscnt  (req.wr && (req.sel == SEL_PSC)),
        .ld_reload (req.wr && (req.sel == SEL_RELOAD)),
        .wdata     (req.data),
        .count     (evt_count),
        .pscnt     (evt_pscnt),
        .reload    (evt_reload)
    );

    // Read mux and registered return
    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        case (req.sel)
            SEL_LED:    rd_mux = DATA_W'(led_q);
            SEL_BTN:    rd_mux = DATA_W'(btn_s);
            SEL_SEC:    rd_mux = wall_val[0];
            SEL_CENTI:  rd_mux = wall_val[1];
            SEL_EVT:    rd_mux = evt_count;
            SEL_RELOAD: rd_mux = evt_reload;
            SEL_PSC:    rd_mux = evt_pscnt;
            SEL_AUX:    rd_mux = aux_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         prdata <= '0;
        else if (req.rd) prdata <= rd_mux;
        else             prdata <= '0;
    end
endmodule

// File: rtl/sys_ctrl_regs_chk.sv
module sys_ctrl_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic [11:0] paddr,
    input logic [31:0] pwdata,
    input logic [31:0] prdata,
    input logic [1:0]  btn_in,
    input logic [1:0]  led_out
);
    logic acc_rd, acc_wr;
    assign acc_rd = psel && penable && !pwrite;
    assign acc_wr = psel && penable && pwrite;

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (prdata == 32'h0 && led_out == 2'b00));

    a_r2_led_takes_write: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && paddr == 12'h000) |=> (led_out == $past(pwdata[1:0])));

    a_r2_led_holds: assert property (@(posedge clk) disable iff (rst)
        !(acc_wr && paddr == 12'h000) |=> $stable(led_out));

    a_r3_button_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && paddr == 12'h008) |=> (prdata[31:2] == 30'h0));

    a_r9_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && (paddr == 12'h004 || paddr == 12'h04D)) |=> (prdata == 32'h0));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !acc_rd |=> (prdata == 32'h0));
endmodule

bind sys_ctrl_regs sys_ctrl_regs_chk u_chk (.*);

// File: tb/sys_ctrl_regs_tb_top.sv
module sys_ctrl_regs_tb_top;
    localparam int unsigned CLK_HZ = 2000;
    localparam int unsigned PS_DIV = 3;
    localparam int unsigned D_SEC  = CLK_HZ;
    localparam int unsigned D_CEN  = CLK_HZ / 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [1:0]  btn_in = 2'b00;
    logic [1:0]  led_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sys_ctrl_regs #(.CLK_HZ(CLK_HZ), .PS_DIV(PS_DIV)) dut_i (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .btn_in(btn_in), .led_out(led_out)
    );

    // Reference model built from the requirements
    logic [1:0]  m_led, m_b1, m_b2;
    logic [31:0] m_aux, m_sec, m_cen, m_evt, m_psc, m_rl;
    int unsigned d_sec, d_cen, d_ps;
    logic bw;
    assign bw = psel && penable && pwrite;

    always @(posedge clk) begin
        if (rst) begin
            m_led <= 0; m_b1 <= 0; m_b2 <= 0; m_aux <= 0; m_sec <= 0; m_cen <= 0;
            m_evt <= 0; m_psc <= 0; m_rl <= 0; d_sec <= 0; d_cen <= 0; d_ps <= 0;
        end else begin
            m_b1 <= btn_in; m_b2 <= m_b1;
            d_sec <= (d_sec == D_SEC - 1) ? 0 : d_sec + 1;
            d_cen <= (d_cen == D_CEN - 1) ? 0 : d_cen + 1;
            d_ps  <= (d_ps  == PS_DIV - 1) ? 0 : d_ps + 1;
            if (bw && paddr == 12'h000) m_led <= pwdata[1:0];
            if (bw && paddr == 12'h04C) m_aux <= pwdata;
            if (bw && paddr == 12'h01C) m_rl  <= pwdata;
            if (bw && paddr == 12'h010) m_sec <= pwdata;
            else if (d_sec == D_SEC - 1) m_sec <= m_sec + 1;
            if (bw && paddr == 12'h014) m_cen <= pwdata;
            else if (d_cen == D_CEN - 1) m_cen <= m_cen + 1;
            if (bw && paddr == 12'h018) m_evt <= pwdata;
            else if (d_ps == PS_DIV - 1 && m_psc == 0) m_evt <= m_evt + 1;
            if (bw && paddr == 12'h020) m_psc <= pwdata;
            else if (d_ps == PS_DIV - 1) m_psc <= (m_psc == 0) ? m_rl : m_psc - 1;
        end
    end

    function automatic logic [31:0] model_read(input logic [11:0] a);
        case (a)
            12'h000: return {30'h0, m_led};
            12'h008: return {30'h0, m_b2};
            12'h010: return m_sec;
            12'h014: return m_cen;
            12'h018: return m_evt;
            12'h01C: return m_rl;
            12'h020: return m_psc;
            12'h04C: return m_aux;
            default: return 32'h0;
        endcase
    endfunction

    // Scoreboard
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_fire = 1'b0;

    always @(posedge clk) rd_fire <= !rst && psel && penable && !pwrite;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rd_fire) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected read data", 32'h1, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, prdata, e);
            end
        end
    end

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    // use_fix = 0 takes the model value at the access phase
    task automatic bus_rd(input logic [11:0] a, input string t,
                          input bit use_fix = 0, input logic [31:0] fix = 0);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk);
        penable = 1;
        exp_q.push_back(use_fix ? fix : model_read(a));
        tag_q.push_back(t);
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1 reset state
        check("R1 led_out after reset", {30'h0, led_out}, 32'h0);
        bus_rd(12'h000, "R1 LED reset", 1, 32'h0);
        bus_rd(12'h04C, "R1 MISC reset", 1, 32'h0);
        bus_rd(12'h01C, "R1 reload reset", 1, 32'h0);

        // R2 LED masking
        bus_wr(12'h000, 32'hFFFF_FFFF);
        check("R10 prdata zero after write", prdata, 32'h0);
        check("R2 led_out", {30'h0, led_out}, 32'h3);
        bus_rd(12'h000, "R2 LED masked", 1, 32'h3);
        bus_wr(12'h000, 32'hFFFF_FFFE);
        bus_rd(12'h000, "R2 LED bit0 clear", 1, 32'h2);

        // R4 MISC read-as-written
        bus_wr(12'h04C, 32'hA5C3_0F96);
        bus_rd(12'h04C, "R4 MISC full word", 1, 32'hA5C3_0F96);

        // R3 button sync and write ignore
        btn_in = 2'b10;
        idle(3);
        bus_rd(12'h008, "R3 button value", 1, 32'h2);
        bus_wr(12'h008, 32'hFFFF_FFFF);
        bus_rd(12'h008, "R3 button write ignored", 1, 32'h2);

        // R9 holes and misaligned
        bus_wr(12'h004, 32'hFFFF_FFFF);
        bus_wr(12'h04D, 32'h0000_0000);
        bus_rd(12'h004, "R9 hole reads zero", 1, 32'h0);
        bus_rd(12'h04D, "R9 misaligned reads zero", 1, 32'h0);
        bus_rd(12'h04C, "R9 MISC untouched by misaligned write", 1, 32'hA5C3_0F96);
        bus_rd(12'h000, "R9 LED untouched", 1, 32'h2);

        // R5 counting
        idle(150);
        bus_rd(12'h014, "R5 centi counter");
        bus_rd(12'h010, "R5 second counter");
        bus_wr(12'h010, 32'hFFFF_FFFF);
        idle(D_SEC + 10);
        bus_rd(12'h010, "R5 second counter wraps", 1, 32'h0);

        // R6 preset and collision with tick
        bus_wr(12'h014, 32'h0000_1000);
        idle(45);
        bus_rd(12'h014, "R6 preset then count");
        while (d_cen != D_CEN - 3) @(negedge clk);
        bus_wr(12'h014, 32'h0000_7777);
        bus_rd(12'h014, "R6 write wins over tick", 1, 32'h0000_7777);

        // R7 prescaler
        bus_wr(12'h01C, 32'h2);
        idle(30);
        bus_rd(12'h020, "R7 prescaler count");
        bus_rd(12'h018, "R7 event count");
        bus_wr(12'h01C, 32'h0);
        idle(25);
        bus_rd(12'h018, "R7 reload zero every tick");
        bus_rd(12'h020, "R7 pscnt stuck at zero", 1, 32'h0);

        // R8 writes and collision
        bus_wr(12'h018, 32'h0000_0100);
        bus_rd(12'h018, "R8 event count write");
        bus_wr(12'h01C, 32'h4);
        bus_wr(12'h020, 32'h0);
        while (d_ps != PS_DIV - 1 - 2 + (PS_DIV <= 2 ? PS_DIV : 0)) @(negedge clk);
        bus_wr(12'h020, 32'h0000_0009);
        bus_rd(12'h020, "R8 pscnt write in tick cycle");
        bus_rd(12'h018, "R8 event count alongside pscnt write");
        idle(20);
        bus_rd(12'h020, "R8 pscnt counting after write");

        idle(4);
        check("R10 all reads returned", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule